// File: doc/BRIEF.md
# Thread-Tagged Address Translation Buffer

This block is a small, fully associative translation buffer for a core that runs several hardware threads, each of which may live in its own address space. Every entry records the owning thread number, a virtual page number and a physical page number. A lookup presents a thread number and a virtual address. It hits only when some valid entry agrees on both the thread number and the virtual page. On a hit the block returns the physical address: the stored physical page with the untouched page offset appended. That physical page is intended for the physical tag comparison of a data cache that is indexed by virtual address and tagged by physical address.

Because the thread number takes part in every match, translations from different threads sit side by side. Two threads may map the same virtual page to different frames, and a thread switch needs no flush. The buffer is loaded through a fill port, normally driven by an external page walker. It is emptied either one thread at a time or all at once through two invalidate controls.

Top module: `thread_tlb`

## Requirements
- R1: After a synchronous active-high reset every entry is invalid, the round-robin pointer is 0, and every lookup misses.
- R2: A lookup hits only if a valid entry matches both the requesting thread number and the virtual page number (upper VPN_W bits of the virtual address). On a hit, lk_paddr is the stored physical page in its upper PPN_W bits, with the low OFF_W bits of lk_vaddr copied unchanged below it.
- R3: The lookup is combinational: hit and address follow lk_tid and lk_vaddr within the same cycle. An accepted fill is visible to lookups from the cycle after the clock edge that captured it.
- R4: Entries with the same virtual page number but different thread numbers may be valid together, and each returns its own physical page; at most one entry matches any lookup.
- R5: A fill whose thread number and virtual page match a valid entry rewrites that entry's physical page in place and never creates a second copy.
- R6: A fill that matches no entry is written into the lowest-numbered invalid entry when one exists.
- R7: When all entries are valid, a non-matching fill replaces the entry selected by the round-robin pointer, which then advances by one modulo ENTRIES. The pointer moves only on such a replacement.
- R8: A per-thread invalidate clears exactly the valid entries tagged with inv_tid and leaves every other entry in place.
- R9: A global invalidate clears every entry.
- R10: A fill presented in a cycle in which either invalidate is asserted is discarded.
- R11: On a miss lk_paddr is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_tid | input | TID_W | Thread number of the lookup |
| lk_vaddr | input | VPN_W+OFF_W | Virtual address to translate |
| lk_hit | output | 1 | Lookup hit |
| lk_paddr | output | PPN_W+OFF_W | Translated physical address, zero on a miss |
| fl_valid | input | 1 | Fill request for this cycle |
| fl_tid | input | TID_W | Thread number of the fill |
| fl_vpn | input | VPN_W | Virtual page number of the fill |
| fl_ppn | input | PPN_W | Physical page number of the fill |
| inv_tid_valid | input | 1 | Invalidate all entries of one thread |
| inv_tid | input | TID_W | Thread whose entries are invalidated |
| inv_all | input | 1 | Invalidate every entry |

## Verification
Lookups are tried with the right page under the wrong thread and with one page mapped for two threads. This separates a thread-aware match from a page-only match. Offsets at both ends of the page show that the offset passes straight through. The test refills a resident key and then overflows the buffer. The eviction pattern that follows tells in-place update apart from duplication, and round-robin replacement apart from free-slot allocation. Thread-selective invalidates, fills colliding with invalidates and a global clear each leave a distinct set of surviving translations, and lookups read that set back.

// File: rtl/tlb_thread_pkg.sv
package tlb_thread_pkg;

    localparam int DEF_ENTRIES = 4;
    localparam int DEF_TID_W   = 2;
    localparam int DEF_VPN_W   = 8;
    localparam int DEF_PPN_W   = 8;
    localparam int DEF_OFF_W   = 4;

    // How a fill lands in the entry file
    typedef enum logic [1:0] {
        WR_NONE   = 2'd0,
        WR_UPDATE = 2'd1,
        WR_FREE   = 2'd2,
        WR_EVICT  = 2'd3
    } wr_kind_e;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tlb_tag_match.sv
module tlb_tag_match #(
    parameter int ENTRIES = 4,
    parameter int TID_W   = 2,
    parameter int VPN_W   = 8
) (
    input  logic [ENTRIES-1:0]            valid_vec,
    input  logic [ENTRIES-1:0][TID_W-1:0] tid_arr,
    input  logic [ENTRIES-1:0][VPN_W-1:0] vpn_arr,
    input  logic [TID_W-1:0]              req_tid,
    input  logic [VPN_W-1:0]              req_vpn,
    output logic [ENTRIES-1:0]            match_vec
);

    // Both the owning thread and the page must agree
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign match_vec[e] = valid_vec[e]
                            && (tid_arr[e] == req_tid)
                            && (vpn_arr[e] == req_vpn);
    end

endmodule

// File: rtl/tlb_ppn_select.sv
module tlb_ppn_select #(
    parameter int ENTRIES = 4,
    parameter int PPN_W   = 8
) (
    input  logic [ENTRIES-1:0]            sel_vec,
    input  logic [ENTRIES-1:0][PPN_W-1:0] ppn_arr,
    output logic                          any_sel,
    output logic [PPN_W-1:0]              ppn_out
);

    assign any_sel = |sel_vec;

    // AND-OR mux; selection is one-hot or empty
    always_comb begin
        ppn_out = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            ppn_out = ppn_out | ({PPN_W{sel_vec[e]}} & ppn_arr[e]);
        end
    end

endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick
    import tlb_thread_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] fill_hit_vec,
    input  logic               fill_go,
    output logic [ENTRIES-1:0] wr_onehot,
    output wr_kind_e           wr_kind
);

    localparam int IW = idx_w(ENTRIES);
    localparam logic [IW-1:0] LAST_IDX = IW'(ENTRIES - 1);
    localparam logic [ENTRIES-1:0] ONE = ENTRIES'(1);

    logic [IW-1:0]      rr_q;
    logic [ENTRIES-1:0] free_vec;
    logic [ENTRIES-1:0] free_low;
    logic [ENTRIES-1:0] rr_onehot;

    assign free_vec  = ~valid_vec;
    assign free_low  = free_vec & (~free_vec + ONE);
    assign rr_onehot = ONE << rr_q;

    always_comb begin
        if (!fill_go) begin
            wr_kind   = WR_NONE;
            wr_onehot = '0;
        end else if (|fill_hit_vec) begin
            wr_kind   = WR_UPDATE;
            wr_onehot = fill_hit_vec;
        end else if (|free_vec) begin
            wr_kind   = WR_FREE;
            wr_onehot = free_low;
        end else begin
            wr_kind   = WR_EVICT;
            wr_onehot = rr_onehot;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (wr_kind == WR_EVICT) begin
            rr_q <= (rr_q == LAST_IDX) ? '0 : rr_q + IW'(1);
        end
    end

endmodule

// File: rtl/tlb_entry_file.sv
module tlb_entry_file #(
    parameter int ENTRIES = 4,
    parameter int TID_W   = 2,
    parameter int VPN_W   = 8,
    parameter int PPN_W   = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [ENTRIES-1:0]            wr_onehot,
    input  logic [TID_W-1:0]              wr_tid,
    input  logic [VPN_W-1:0]              wr_vpn,
    input  logic [PPN_W-1:0]              wr_ppn,
    input  logic                          clr_all,
    input  logic                          clr_thread,
    input  logic [TID_W-1:0]              clr_tid,
    output logic [ENTRIES-1:0]            valid_vec,
    output logic [ENTRIES-1:0][TID_W-1:0] tid_arr,
    output logic [ENTRIES-1:0][VPN_W-1:0] vpn_arr,
    output logic [ENTRIES-1:0][PPN_W-1:0] ppn_arr
);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_vec[e] <= 1'b0;
                tid_arr[e]   <= '0;
                vpn_arr[e]   <= '0;
                ppn_arr[e]   <= '0;
            end else if (clr_all) begin
                valid_vec[e] <= 1'b0;
            end else if (clr_thread && (tid_arr[e] == clr_tid)) begin
                valid_vec[e] <= 1'b0;
            end else if (wr_onehot[e]) begin
                valid_vec[e] <= 1'b1;
                tid_arr[e]   <= wr_tid;
                vpn_arr[e]   <= wr_vpn;
                ppn_arr[e]   <= wr_ppn;
            end
        end
    end

endmodule

// File: rtl/thread_tlb.sv
module thread_tlb
    import tlb_thread_pkg::*;
#(
    parameter int ENTRIES = DEF_ENTRIES,
    parameter int TID_W   = DEF_TID_W,
    parameter int VPN_W   = DEF_VPN_W,
    parameter int PPN_W   = DEF_PPN_W,
    parameter int OFF_W   = DEF_OFF_W,
    localparam int VA_W   = VPN_W + OFF_W,
    localparam int PA_W   = PPN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TID_W-1:0] lk_tid,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             lk_hit,
    output logic [PA_W-1:0]  lk_paddr,
    input  logic             fl_valid,
    input  logic [TID_W-1:0] fl_tid,
    input  logic [VPN_W-1:0] fl_vpn,
    input  logic [PPN_W-1:0] fl_ppn,
    input  logic             inv_tid_valid,
    input  logic [TID_W-1:0] inv_tid,
    input  logic             inv_all
);

    logic [ENTRIES-1:0]            valid_vec;
    logic [ENTRIES-1:0][TID_W-1:0] tid_arr;
    logic [ENTRIES-1:0][VPN_W-1:0] vpn_arr;
    logic [ENTRIES-1:0][PPN_W-1:0] ppn_arr;

    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] fl_match;
    logic [ENTRIES-1:0] wr_onehot;
    wr_kind_e           wr_kind;
    logic               fill_go;
    logic               sel_any;
    logic [PPN_W-1:0]   sel_ppn;
    logic [VPN_W-1:0]   lk_vpn;
    logic [OFF_W-1:0]   lk_off;

    assign lk_vpn  = lk_vaddr[VA_W-1:OFF_W];
    assign lk_off  = lk_vaddr[OFF_W-1:0];
    assign fill_go = fl_valid && !inv_all && !inv_tid_valid;

    tlb_tag_match #(.ENTRIES(ENTRIES), .TID_W(TID_W), .VPN_W(VPN_W)) u_lk_match (
        .valid_vec (valid_vec),
        .tid_arr   (tid_arr),
        .vpn_arr   (vpn_arr),
        .req_tid   (lk_tid),
        .req_vpn   (lk_vpn),
        .match_vec (lk_match)
    );

    tlb_tag_match #(.ENTRIES(ENTRIES), .TID_W(TID_W), .VPN_W(VPN_W)) u_fl_match (
        .valid_vec (valid_vec),
        .tid_arr   (tid_arr),
        .vpn_arr   (vpn_arr),
        .req_tid   (fl_tid),
        .req_vpn   (fl_vpn),
        .match_vec (fl_match)
    );

    tlb_ppn_select #(.ENTRIES(ENTRIES), .PPN_W(PPN_W)) u_sel (
        .sel_vec (lk_match),
        .ppn_arr (ppn_arr),
        .any_sel (sel_any),
        .ppn_out (sel_ppn)
    );

    tlb_victim_pick #(.ENTRIES(ENTRIES)) u_victim (
        .clk          (clk),
        .rst          (rst),
        .valid_vec    (valid_vec),
        .fill_hit_vec (fl_match),
        .fill_go      (fill_go),
        .wr_onehot    (wr_onehot),
        .wr_kind      (wr_kind)
    );

    tlb_entry_file #(.ENTRIES(ENTRIES), .TID_W(TID_W), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_file (
        .clk        (clk),
        .rst        (rst),
        .wr_onehot  (wr_onehot),
        .wr_tid     (fl_tid),
        .wr_vpn     (fl_vpn),
        .wr_ppn     (fl_ppn),
        .clr_all    (inv_all),
        .clr_thread (inv_tid_valid),
        .clr_tid    (inv_tid),
        .valid_vec  (valid_vec),
        .tid_arr    (tid_arr),
        .vpn_arr    (vpn_arr),
        .ppn_arr    (ppn_arr)
    );

    assign lk_hit   = sel_any;
    assign lk_paddr = sel_any ? {sel_ppn, lk_off} : '0;

endmodule

// File: rtl/tlb_thread_checker.sv
module tlb_thread_checker #(
    parameter int ENTRIES = 4,
    parameter int TID_W   = 2,
    parameter int VPN_W   = 8,
    parameter int PA_W    = 12
) (
    input logic                          clk,
    input logic                          rst,
    input logic [ENTRIES-1:0]            valid_vec,
    input logic [ENTRIES-1:0][TID_W-1:0] tid_arr,
    input logic [ENTRIES-1:0][VPN_W-1:0] vpn_arr,
    input logic [ENTRIES-1:0]            lk_match,
    input logic                          lk_hit,
    input logic [PA_W-1:0]               lk_paddr,
    input logic                          fl_valid,
    input logic [TID_W-1:0]              fl_tid,
    input logic [VPN_W-1:0]              fl_vpn,
    input logic                          inv_tid_valid,
    input logic [TID_W-1:0]              inv_tid,
    input logic                          inv_all
);

    logic [TID_W-1:0]   q_inv_tid;
    logic [TID_W-1:0]   q_fl_tid;
    logic [VPN_W-1:0]   q_fl_vpn;
    logic [ENTRIES-1:0] left_of_thread;
    logic [ENTRIES-1:0] copies_of_fill;

    always_ff @(posedge clk) begin
        q_inv_tid <= inv_tid;
        q_fl_tid  <= fl_tid;
        q_fl_vpn  <= fl_vpn;
    end

    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            left_of_thread[e] = valid_vec[e] && (tid_arr[e] == q_inv_tid);
            copies_of_fill[e] = valid_vec[e] && (tid_arr[e] == q_fl_tid)
                              && (vpn_arr[e] == q_fl_vpn);
        end
    end

    assert_global_clear_R9: assert property (@(posedge clk) disable iff (rst)
        inv_all |=> (valid_vec == '0));

    assert_thread_clear_R8: assert property (@(posedge clk) disable iff (rst)
        inv_tid_valid |=> (left_of_thread == '0));

    assert_single_copy_R5: assert property (@(posedge clk) disable iff (rst)
        (fl_valid && !inv_all && !inv_tid_valid) |=> ($countones(copies_of_fill) == 1));

    assert_unique_match_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match));

    assert_miss_zero_R11: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_paddr == '0));

endmodule

bind thread_tlb tlb_thread_checker #(
    .ENTRIES (ENTRIES),
    .TID_W   (TID_W),
    .VPN_W   (VPN_W),
    .PA_W    (PA_W)
) u_checker (
    .clk           (clk),
    .rst           (rst),
    .valid_vec     (valid_vec),
    .tid_arr       (tid_arr),
    .vpn_arr       (vpn_arr),
    .lk_match      (lk_match),
    .lk_hit        (lk_hit),
    .lk_paddr      (lk_paddr),
    .fl_valid      (fl_valid),
    .fl_tid        (fl_tid),
    .fl_vpn        (fl_vpn),
    .inv_tid_valid (inv_tid_valid),
    .inv_tid       (inv_tid),
    .inv_all       (inv_all)
);

// File: tb/thread_tlb_bench.sv
module thread_tlb_bench;

    localparam int TID_W = 2;
    localparam int VPN_W = 8;
    localparam int PPN_W = 8;
    localparam int OFF_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [TID_W-1:0] lk_tid = '0;
    logic [11:0]      lk_vaddr = '0;
    logic             lk_hit;
    logic [11:0]      lk_paddr;
    logic             fl_valid = 1'b0;
    logic [TID_W-1:0] fl_tid = '0;
    logic [VPN_W-1:0] fl_vpn = '0;
    logic [PPN_W-1:0] fl_ppn = '0;
    logic             inv_tid_valid = 1'b0;
    logic [TID_W-1:0] inv_tid = '0;
    logic             inv_all = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    thread_tlb u_thread_tlb (
        .clk           (clk),
        .rst           (rst),
        .lk_tid        (lk_tid),
        .lk_vaddr      (lk_vaddr),
        .lk_hit        (lk_hit),
        .lk_paddr      (lk_paddr),
        .fl_valid      (fl_valid),
        .fl_tid        (fl_tid),
        .fl_vpn        (fl_vpn),
        .fl_ppn        (fl_ppn),
        .inv_tid_valid (inv_tid_valid),
        .inv_tid       (inv_tid),
        .inv_all       (inv_all)
    );

    // Combinational lookup, sampled 1 ns after inputs change, mid-phase
    task automatic look(input logic [1:0] tid, input logic [7:0] vpn,
                        input logic [3:0] off, input bit exp_hit,
                        input logic [7:0] exp_ppn, input string req);
        logic [11:0] exp_pa;
        lk_tid   = tid;
        lk_vaddr = {vpn, off};
        #1;
        exp_pa = exp_hit ? {exp_ppn, off} : 12'h000;
        n_cmp++;
        if (lk_hit !== exp_hit || lk_paddr !== exp_pa) begin
            n_bad++;
            $display("FAIL %s: tid=%0d vpn=%h hit=%0b paddr=%h, expected hit=%0b paddr=%h",
                     req, tid, vpn, lk_hit, lk_paddr, exp_hit, exp_pa);
        end
    endtask

    task automatic fill(input logic [1:0] tid, input logic [7:0] vpn, input logic [7:0] ppn);
        @(negedge clk);
        fl_valid = 1'b1; fl_tid = tid; fl_vpn = vpn; fl_ppn = ppn;
        @(negedge clk);
        fl_valid = 1'b0;
    endtask

    task automatic drop_thread(input logic [1:0] tid);
        @(negedge clk);
        inv_tid_valid = 1'b1; inv_tid = tid;
        @(negedge clk);
        inv_tid_valid = 1'b0;
    endtask

    task automatic t_reset;
        // R1: nothing resident after reset
        for (int t = 0; t < 4; t++) look(2'(t), 8'h12, 4'h3, 1'b0, 8'h00, "R1");
    endtask

    task automatic t_basic;
        fill(2'd0, 8'h12, 8'hA5);
        // R2/R3: both offset extremes, inputs changed without a clock edge
        look(2'd0, 8'h12, 4'h0, 1'b1, 8'hA5, "R2");
        look(2'd0, 8'h12, 4'hF, 1'b1, 8'hA5, "R3");
        // R2: right page, wrong thread; R11 zero address on miss
        look(2'd1, 8'h12, 4'h7, 1'b0, 8'h00, "R2");
        look(2'd0, 8'h13, 4'h7, 1'b0, 8'h00, "R11");
    endtask

    task automatic t_alias;
        fill(2'd1, 8'h12, 8'h3C);
        look(2'd0, 8'h12, 4'h5, 1'b1, 8'hA5, "R4");
        look(2'd1, 8'h12, 4'h5, 1'b1, 8'h3C, "R4");
    endtask

    task automatic t_update_and_evict;
        // R5: refill same key; entries e0 t0/12, e1 t1/12
        fill(2'd0, 8'h12, 8'h77);
        look(2'd0, 8'h12, 4'h1, 1'b1, 8'h77, "R5");
        // R6: free slots e2, e3 taken in order
        fill(2'd2, 8'h20, 8'h22);
        fill(2'd3, 8'h30, 8'h33);
        look(2'd2, 8'h20, 4'h2, 1'b1, 8'h22, "R6");
        look(2'd3, 8'h30, 4'h2, 1'b1, 8'h33, "R6");
        // R7: full; pointer 0 then 1 evicts t0/12 then t1/12
        fill(2'd0, 8'h40, 8'h44);
        look(2'd0, 8'h12, 4'h1, 1'b0, 8'h00, "R5 R7");
        look(2'd1, 8'h12, 4'h1, 1'b1, 8'h3C, "R7");
        fill(2'd1, 8'h50, 8'h55);
        look(2'd1, 8'h12, 4'h1, 1'b0, 8'h00, "R7");
        look(2'd0, 8'h40, 4'h4, 1'b1, 8'h44, "R7");
        look(2'd1, 8'h50, 4'h4, 1'b1, 8'h55, "R7");
    endtask

    task automatic t_thread_inv;
        // R8: drop thread 3 (e3) only
        drop_thread(2'd3);
        look(2'd3, 8'h30, 4'h0, 1'b0, 8'h00, "R8");
        look(2'd2, 8'h20, 4'h0, 1'b1, 8'h22, "R8");
        look(2'd0, 8'h40, 4'h0, 1'b1, 8'h44, "R8");
        // R6: pointer sits at 2, yet the free e3 must be used
        fill(2'd3, 8'h70, 8'h7E);
        look(2'd3, 8'h70, 4'h9, 1'b1, 8'h7E, "R6");
        look(2'd2, 8'h20, 4'h9, 1'b1, 8'h22, "R6");
        drop_thread(2'd2);
        look(2'd2, 8'h20, 4'h0, 1'b0, 8'h00, "R8");
        look(2'd3, 8'h70, 4'h0, 1'b1, 8'h7E, "R8");
    endtask

    task automatic t_fill_collide;
        // R10: fill with per-thread invalidate in the same cycle
        @(negedge clk);
        fl_valid = 1'b1; fl_tid = 2'd0; fl_vpn = 8'h99; fl_ppn = 8'h90;
        inv_tid_valid = 1'b1; inv_tid = 2'd1;
        @(negedge clk);
        fl_valid = 1'b0; inv_tid_valid = 1'b0;
        look(2'd0, 8'h99, 4'h0, 1'b0, 8'h00, "R10");
        look(2'd1, 8'h50, 4'h0, 1'b0, 8'h00, "R8");
        look(2'd0, 8'h40, 4'h0, 1'b1, 8'h44, "R8");
        // R10: fill with global invalidate in the same cycle
        @(negedge clk);
        fl_valid = 1'b1; fl_tid = 2'd2; fl_vpn = 8'hAA; fl_ppn = 8'hAB;
        inv_all = 1'b1;
        @(negedge clk);
        fl_valid = 1'b0; inv_all = 1'b0;
        look(2'd2, 8'hAA, 4'h0, 1'b0, 8'h00, "R10");
    endtask

    task automatic t_global_inv;
        fill(2'd1, 8'h61, 8'h16);
        fill(2'd2, 8'h62, 8'h26);
        look(2'd1, 8'h61, 4'h0, 1'b1, 8'h16, "R9");
        @(negedge clk);
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
        look(2'd1, 8'h61, 4'h0, 1'b0, 8'h00, "R9");
        look(2'd2, 8'h62, 4'h0, 1'b0, 8'h00, "R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_alias();
        t_update_and_evict();
        t_thread_inv();
        t_fill_collide();
        t_global_inv();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete (R1 to R11 unreached), expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule